// File: doc/BRIEF.md
# Eight-Point Inverse Cosine Transform Row Engine

This block turns one vector of eight signed fixed-point frequency coefficients into eight signed samples by a one-dimensional 8-point inverse DCT. All eight coefficients arrive together through a valid/ready port. Eight results leave together with a valid flag a fixed three cycles later. Two of these engines, with a transpose buffer between them, make a 2D transform. This block holds only the row engine.

The cosine weights are the Q15 cosines of multiples of pi/16, and the DC weight is 1/sqrt(2) in Q15. The engine splits each output pair j and 7-j into two parts. One part is a partial sum over the even-indexed inputs and the other is a partial sum over the odd-indexed inputs. Output j is their sum and output 7-j is their difference. A bank of parallel constant multipliers feeds the two sum trees. A final add/subtract butterfly combines them, and a round-and-shift stage returns the result to the input scale.

Products and sums are kept at full precision. Each result is rounded half-up by adding 2^14 and then shifted arithmetically right by 15 bits. The pipeline advances as a whole: it moves whenever the output register is empty or is being read.

Top module: `idct8_butterfly`

## Requirements
- R1: While reset is applied and after it is released, before any vector is accepted, `out_vld` is 0 and `in_rdy` is 1.
- R2: For input vector x, with coefficient k in bits [12k+11:12k] of `in_coef`, output n (bits [16n+15:16n] of `out_pix`) equals floor((S + 2^14) / 2^15). Here S = sum over k of w(n,k)*x[k]. The weight w(n,0) is 23170, and w(n,k) for k>0 is round(32768*cos((2n+1)k*pi/16)).
- R3: When only even-indexed inputs are non-zero, output j equals output 7-j. When only odd-indexed inputs are non-zero, output j plus output 7-j is 0 or 1.
- R4: Rounding is half-up toward plus infinity. A lone DC input of +1 gives +1 on all eight outputs, and a lone DC input of -1 gives -1 on all eight outputs.
- R5: With `out_rdy` held high, a vector accepted at a clock edge appears on `out_pix` with `out_vld` high exactly three edges later.
- R6: With `out_rdy` held high, `in_rdy` stays high and one vector is accepted on every cycle, with results leaving on consecutive cycles.
- R7: When `out_vld` is high and `out_rdy` is low, `in_rdy` is 0. On the next cycle `out_vld` stays high and `out_pix` is unchanged.
- R8: Under any pattern of input valid and output ready, every accepted vector yields exactly one result, in acceptance order.
- R9: Full-scale inputs (every coefficient at -2048 or +2047) produce the exact R2 result without internal overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_vld | input | 1 | Input vector valid |
| in_rdy | output | 1 | Engine can take a vector this cycle |
| in_coef | input | 96 | Eight signed 12-bit coefficients, index k in bits [12k+11:12k] |
| out_vld | output | 1 | Output vector valid |
| out_rdy | input | 1 | Downstream takes the output vector |
| out_pix | output | 128 | Eight signed 16-bit results, index n in bits [16n+15:16n] |

## Verification
The engine is driven with all-zero vectors, lone DC values of +1 and -1, single even-index and single odd-index impulses, full-scale alternating vectors and long runs of random vectors. Random output-ready patterns are mixed in. The lone DC cases expose a wrong rounding direction or a missing rounding constant. The even-only and odd-only impulses separate faults in the even tree from faults in the odd tree, and a swapped add and subtract in the butterfly. Full-scale vectors reveal truncated intermediate widths. Random stalls show whether a vector is dropped, duplicated or reordered, and whether a held output stays stable.

// File: rtl/idct8_pkg.sv
package idct8_pkg;

  localparam int NPT  = 8;
  localparam int HALF = NPT / 2;
  localparam int CW   = 16;   // signed width of a Q15 cosine weight
  localparam int FRAC = 15;   // fraction bits of the weights

  // Q15 cosine of m*pi/16, any integer m >= 0
  function automatic int cos_q15(input int m);
    int mm;
    int sgn;
    int v;
    mm  = m % 32;
    sgn = 1;
    if (mm > 16) mm = 32 - mm;
    if (mm > 8) begin
      mm  = 16 - mm;
      sgn = -1;
    end
    case (mm)
      0:       v = 32768;
      1:       v = 32138;
      2:       v = 30274;
      3:       v = 27246;
      4:       v = 23170;
      5:       v = 18205;
      6:       v = 12540;
      7:       v = 6393;
      default: v = 0;
    endcase
    return sgn * v;
  endfunction

  // weight of input k in output n
  function automatic int weight(input int n, input int k);
    if (k == 0) return 23170;
    return cos_q15((2 * n + 1) * k);
  endfunction

endpackage

// File: rtl/idct8_rst_sync.sv
module idct8_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n = sync_q[1];

endmodule

// File: rtl/idct8_prod_stage.sv
module idct8_prod_stage
  import idct8_pkg::*;
#(
  parameter int IW = 12,
  localparam int PW = IW + CW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 vld_i,
  input  logic [NPT*IW-1:0]    x_i,
  output logic                 vld_o,
  output logic signed [PW-1:0] pe_o [HALF][HALF],
  output logic signed [PW-1:0] po_o [HALF][HALF]
);

  logic signed [PW-1:0] pe_d [HALF][HALF];
  logic signed [PW-1:0] po_d [HALF][HALF];
  logic                 vld_d;

  // one constant multiplier per (output pair, tap)
  for (genvar j = 0; j < HALF; j++) begin : g_pair
    for (genvar t = 0; t < HALF; t++) begin : g_tap
      localparam logic signed [CW-1:0] KE = CW'(weight(j, 2 * t));
      localparam logic signed [CW-1:0] KO = CW'(weight(j, 2 * t + 1));
      logic signed [IW-1:0] xe;
      logic signed [IW-1:0] xo;
      assign xe = x_i[(2*t)*IW +: IW];
      assign xo = x_i[(2*t+1)*IW +: IW];
      always_comb begin
        pe_d[j][t] = xe * KE;
        po_d[j][t] = xo * KO;
      end
    end
  end

  always_comb vld_d = vld_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  vld_o <= 1'b0;
    else if (en) vld_o <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (en) begin
      pe_o <= pe_d;
      po_o <= po_d;
    end
  end

endmodule

// File: rtl/idct8_sum_stage.sv
module idct8_sum_stage
  import idct8_pkg::*;
#(
  parameter int PW = 28,
  localparam int SW = PW + $clog2(HALF)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 vld_i,
  input  logic signed [PW-1:0] pe_i [HALF][HALF],
  input  logic signed [PW-1:0] po_i [HALF][HALF],
  output logic                 vld_o,
  output logic signed [SW-1:0] ev_o [HALF],
  output logic signed [SW-1:0] od_o [HALF]
);

  logic signed [SW-1:0] ev_d [HALF];
  logic signed [SW-1:0] od_d [HALF];

  for (genvar j = 0; j < HALF; j++) begin : g_tree
    always_comb begin
      ev_d[j] = '0;
      od_d[j] = '0;
      for (int t = 0; t < HALF; t++) begin
        ev_d[j] = ev_d[j] + SW'(pe_i[j][t]);
        od_d[j] = od_d[j] + SW'(po_i[j][t]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  vld_o <= 1'b0;
    else if (en) vld_o <= vld_i;
  end

  always_ff @(posedge clk) begin
    if (en) begin
      ev_o <= ev_d;
      od_o <= od_d;
    end
  end

endmodule

// File: rtl/idct8_bfly_stage.sv
module idct8_bfly_stage
  import idct8_pkg::*;
#(
  parameter int SW = 30,
  parameter int OW = 16,
  localparam int AW = SW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 vld_i,
  input  logic signed [SW-1:0] ev_i [HALF],
  input  logic signed [SW-1:0] od_i [HALF],
  output logic                 vld_o,
  output logic [NPT*OW-1:0]    y_o
);

  localparam logic signed [AW-1:0] RND = AW'(1) <<< (FRAC - 1);

  logic [NPT*OW-1:0] y_d;

  for (genvar j = 0; j < HALF; j++) begin : g_bfly
    logic signed [AW-1:0] sum_a;
    logic signed [AW-1:0] dif_a;
    logic signed [AW-1:0] sum_s;
    logic signed [AW-1:0] dif_s;
    always_comb begin
      sum_a = AW'(ev_i[j]) + AW'(od_i[j]) + RND;
      dif_a = AW'(ev_i[j]) - AW'(od_i[j]) + RND;
      sum_s = sum_a >>> FRAC;
      dif_s = dif_a >>> FRAC;
      y_d[j*OW +: OW]         = sum_s[OW-1:0];
      y_d[(NPT-1-j)*OW +: OW] = dif_s[OW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  vld_o <= 1'b0;
    else if (en) vld_o <= vld_i;
  end

  always_ff @(posedge clk) begin
    if (en) y_o <= y_d;
  end

endmodule

// File: rtl/idct8_butterfly.sv
module idct8_butterfly
  import idct8_pkg::*;
#(
  parameter int IW = 12,
  parameter int OW = 16
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              in_vld,
  output logic              in_rdy,
  input  logic [NPT*IW-1:0] in_coef,
  output logic              out_vld,
  input  logic              out_rdy,
  output logic [NPT*OW-1:0] out_pix
);

  localparam int PW = IW + CW;
  localparam int SW = PW + $clog2(HALF);

  logic rst_n;
  logic adv;
  logic v1;
  logic v2;
  logic signed [PW-1:0] pe [HALF][HALF];
  logic signed [PW-1:0] po [HALF][HALF];
  logic signed [SW-1:0] ev [HALF];
  logic signed [SW-1:0] od [HALF];

  idct8_rst_sync u_rst (
    .clk    (clk),
    .arst_n (arst_n),
    .rst_n  (rst_n)
  );

  // the whole pipe moves when the output slot is free or being drained
  assign adv    = !out_vld || out_rdy;
  assign in_rdy = adv;

  idct8_prod_stage #(.IW(IW)) u_prod (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (adv),
    .vld_i (in_vld),
    .x_i   (in_coef),
    .vld_o (v1),
    .pe_o  (pe),
    .po_o  (po)
  );

  idct8_sum_stage #(.PW(PW)) u_sum (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (adv),
    .vld_i (v1),
    .pe_i  (pe),
    .po_i  (po),
    .vld_o (v2),
    .ev_o  (ev),
    .od_o  (od)
  );

  idct8_bfly_stage #(.SW(SW), .OW(OW)) u_bfly (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (adv),
    .vld_i (v2),
    .ev_i  (ev),
    .od_i  (od),
    .vld_o (out_vld),
    .y_o   (out_pix)
  );

endmodule

// File: rtl/idct8_butterfly_chk.sv
module idct8_butterfly_chk #(
  parameter int IW = 12,
  parameter int OW = 16
) (
  input logic            clk,
  input logic            arst_n,
  input logic            in_vld,
  input logic            in_rdy,
  input logic [8*IW-1:0] in_coef,
  input logic            out_vld,
  input logic            out_rdy,
  input logic [8*OW-1:0] out_pix
);

  // R7: a held result keeps its value
  a_r7_hold_data: assert property (@(posedge clk) disable iff (!arst_n)
    (out_vld && !out_rdy) |=> (out_vld && $stable(out_pix)));

  // R7: nothing is taken while the output is blocked
  a_r7_block_input: assert property (@(posedge clk) disable iff (!arst_n)
    (out_vld && !out_rdy) |-> !in_rdy);

  // R6: an empty output slot never refuses input
  a_r6_ready_when_empty: assert property (@(posedge clk) disable iff (!arst_n)
    !out_vld |-> in_rdy);

  // R5: three free-running edges after acceptance the result is present
  a_r5_latency: assert property (@(posedge clk) disable iff (!arst_n)
    ($past(in_vld && in_rdy, 3) && $past(in_rdy, 2) && $past(in_rdy, 1)) |-> out_vld);

endmodule

bind idct8_butterfly idct8_butterfly_chk #(.IW(IW), .OW(OW)) u_chk (
  .clk     (clk),
  .arst_n  (arst_n),
  .in_vld  (in_vld),
  .in_rdy  (in_rdy),
  .in_coef (in_coef),
  .out_vld (out_vld),
  .out_rdy (out_rdy),
  .out_pix (out_pix)
);

// File: tb/sim_idct8_butterfly.sv
module sim_idct8_butterfly;

  localparam int IW = 12;
  localparam int OW = 16;

  logic            clk = 1'b0;
  logic            arst_n;
  logic            in_vld;
  logic            in_rdy;
  logic [8*IW-1:0] in_coef;
  logic            out_vld;
  logic            out_rdy;
  logic [8*OW-1:0] out_pix;

  always #5 clk = ~clk;

  idct8_butterfly #(.IW(IW), .OW(OW)) u0 (
    .clk     (clk),
    .arst_n  (arst_n),
    .in_vld  (in_vld),
    .in_rdy  (in_rdy),
    .in_coef (in_coef),
    .out_vld (out_vld),
    .out_rdy (out_rdy),
    .out_pix (out_pix)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [8*OW-1:0] exp_q [$];
  logic [8*OW-1:0] last_pix;
  logic            last_vld;
  int              n_out = 0;
  int              n_in = 0;
  bit              was_held = 0;
  logic [8*OW-1:0] held_pix;

  function automatic longint wq(int n, int k);
    real r;
    if (k == 0) r = 32768.0 * $sqrt(0.5);
    else        r = 32768.0 * $cos((2.0 * n + 1.0) * k * 3.14159265358979 / 16.0);
    if (r >= 0.0) return longint'($rtoi(r + 0.5));
    return -longint'($rtoi(-r + 0.5));
  endfunction

  function automatic logic [8*OW-1:0] model(logic [8*IW-1:0] v);
    logic [8*OW-1:0] y;
    for (int n = 0; n < 8; n++) begin
      longint acc = 0;
      longint res;
      for (int k = 0; k < 8; k++)
        acc += wq(n, k) * longint'($signed(v[k*IW +: IW]));
      res = (acc + 16384) >>> 15;
      y[n*OW +: OW] = res[OW-1:0];
    end
    return y;
  endfunction

  function automatic logic [8*IW-1:0] pack(int a0, int a1, int a2, int a3,
                                           int a4, int a5, int a6, int a7);
    int a [8];
    logic [8*IW-1:0] v;
    a = '{a0, a1, a2, a3, a4, a5, a6, a7};
    for (int k = 0; k < 8; k++) v[k*IW +: IW] = a[k][IW-1:0];
    return v;
  endfunction

  function automatic int lane(logic [8*OW-1:0] y, int n);
    return int'($signed(y[n*OW +: OW]));
  endfunction

  task automatic check(bit ok, string req, string act, string exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%s expected=%s", req, act, exp);
    end
  endtask

  // one cycle: drive at the falling edge, observe the pre-edge state
  task automatic step(logic v, logic [8*IW-1:0] d, logic rdy, output bit acc);
    @(negedge clk);
    in_vld  = v;
    in_coef = d;
    out_rdy = rdy;
    #1;
    if (was_held) begin
      check(out_vld && out_pix == held_pix, "R7",
            $sformatf("vld=%0b %h", out_vld, out_pix), $sformatf("vld=1 %h", held_pix));
    end
    last_vld = out_vld;
    last_pix = out_pix;
    was_held = out_vld && !rdy;
    held_pix = out_pix;
    if (was_held)
      check(!in_rdy, "R7", $sformatf("in_rdy=%0b", in_rdy), "in_rdy=0");
    if (out_vld && rdy) begin
      n_out++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R8", "extra result", "no result");
      end else begin
        logic [8*OW-1:0] e;
        e = exp_q.pop_front();
        check(out_pix == e, "R2", $sformatf("%h", out_pix), $sformatf("%h", e));
      end
    end
    acc = v && in_rdy;
    if (acc) begin
      exp_q.push_back(model(d));
      n_in++;
    end
  endtask

  task automatic drain();
    bit a;
    for (int i = 0; i < 8; i++) step(1'b0, '0, 1'b1, a);
  endtask

  // send one vector on an idle pipe and return its result and latency
  task automatic run_single(logic [8*IW-1:0] d, output logic [8*OW-1:0] y,
                            output int lat);
    bit a;
    drain();
    step(1'b1, d, 1'b1, a);
    lat = 0;
    y   = '0;
    for (int i = 0; i < 6; i++) begin
      step(1'b0, '0, 1'b1, a);
      lat++;
      if (last_vld) begin
        y = last_pix;
        break;
      end
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [8*OW-1:0] y;
    logic [8*OW-1:0] e;
    int lat;
    bit a;
    bit ok;
    void'($urandom(32'd1234));
    arst_n  = 1'b0;
    in_vld  = 1'b0;
    in_coef = '0;
    out_rdy = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1 during reset
    check(!out_vld && in_rdy, "R1", $sformatf("vld=%0b rdy=%0b", out_vld, in_rdy), "vld=0 rdy=1");
    @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check(!out_vld && in_rdy, "R1", $sformatf("vld=%0b rdy=%0b", out_vld, in_rdy), "vld=0 rdy=1");

    // R5 latency, zero vector
    run_single('0, y, lat);
    check(lat == 3, "R5", $sformatf("%0d", lat), "3");
    check(y == '0, "R2", $sformatf("%h", y), "0");

    // R4 rounding on lone DC of +1 and -1
    run_single(pack(1, 0, 0, 0, 0, 0, 0, 0), y, lat);
    ok = 1;
    for (int n = 0; n < 8; n++) if (lane(y, n) != 1) ok = 0;
    check(ok, "R4", $sformatf("%h", y), "all +1");
    run_single(pack(-1, 0, 0, 0, 0, 0, 0, 0), y, lat);
    ok = 1;
    for (int n = 0; n < 8; n++) if (lane(y, n) != -1) ok = 0;
    check(ok, "R4", $sformatf("%h", y), "all -1");

    // R3 even-only symmetry, odd-only antisymmetry
    run_single(pack(0, 0, 1000, 0, -300, 0, 77, 0), y, lat);
    ok = 1;
    for (int j = 0; j < 4; j++) if (lane(y, j) != lane(y, 7 - j)) ok = 0;
    check(ok, "R3", $sformatf("%h", y), "mirror equal");
    run_single(pack(0, 513, 0, -777, 0, 91, 0, 2047), y, lat);
    ok = 1;
    for (int j = 0; j < 4; j++) begin
      int s;
      s = lane(y, j) + lane(y, 7 - j);
      if (s != 0 && s != 1) ok = 0;
    end
    check(ok, "R3", $sformatf("%h", y), "mirror sum 0 or 1");

    // R9 full scale
    run_single(pack(2047, 2047, 2047, 2047, 2047, 2047, 2047, 2047), y, lat);
    e = model(pack(2047, 2047, 2047, 2047, 2047, 2047, 2047, 2047));
    check(y == e, "R9", $sformatf("%h", y), $sformatf("%h", e));
    run_single(pack(-2048, 2047, -2048, 2047, -2048, 2047, -2048, 2047), y, lat);
    e = model(pack(-2048, 2047, -2048, 2047, -2048, 2047, -2048, 2047));
    check(y == e, "R9", $sformatf("%h", y), $sformatf("%h", e));
    run_single(pack(-2048, -2048, -2048, -2048, -2048, -2048, -2048, -2048), y, lat);
    e = model(pack(-2048, -2048, -2048, -2048, -2048, -2048, -2048, -2048));
    check(y == e, "R9", $sformatf("%h", y), $sformatf("%h", e));

    // R6 back-to-back burst
    drain();
    begin
      int taken = 0;
      int outs;
      outs = n_out;
      for (int i = 0; i < 20; i++) begin
        step(1'b1, pack(i * 50 - 500, i, -i, 3 * i, 0, -7 * i, 11, i * 90), 1'b1, a);
        if (a) taken++;
      end
      check(taken == 20, "R6", $sformatf("%0d", taken), "20");
      for (int i = 0; i < 3; i++) step(1'b0, '0, 1'b1, a);
      check(n_out - outs == 20, "R6", $sformatf("%0d", n_out - outs), "20");
    end

    // R8 random data with random valid and ready
    for (int i = 0; i < 3000; i++) begin
      logic [8*IW-1:0] d;
      for (int k = 0; k < 8; k++) d[k*IW +: IW] = IW'($urandom);
      step(($urandom % 4) != 0, d, ($urandom % 3) != 0, a);
    end
    drain();
    check(exp_q.size() == 0 && n_in == n_out, "R8",
          $sformatf("in=%0d out=%0d left=%0d", n_in, n_out, exp_q.size()), "in==out left=0");

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule